// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the instruction decoder of a hart that has the hypervisor extension. Each cycle the decoder presents the current privilege mode, a one-hot flag for the kind of privileged or unit-gated instruction being decoded, and the live values of the status, hypervisor-status, environment-configuration, floating-point and vector control fields that govern that instruction. For each instruction class the block reports one of three things: the instruction is legal, it must raise an illegal-instruction exception, or it must raise a virtual-instruction exception.

The rules cover address-translation fences, the hypervisor fences and guest load/store instructions, wait-for-interrupt and the short reservation wait, the FP and vector unit enables, the dynamic rounding mode, and the three cache-block operation groups. For the cache-block invalidate it also reports when the operation must be carried out as a flush, based on the environment-configuration fields of every level between the current mode and machine mode.

The block has no state of its own. An optional output register stage, selected by a parameter and on by default, adds one cycle of latency so the results can be timed into the next decode stage.

Top module: `priv_legality_chk`

## Requirements
- R1: Class flags use bit positions 0 sfence.vma, 1 partial sfence forms, 2 hfence.gvma, 3 hfence.vvma, 4 guest load/store, 5 WFI, 6 WRS.NTO, 7 scalar FP, 8 FP with dynamic rounding, 9 integer vector, 10 vector FP, 11 CBO.ZERO, 12 CBO.CLEAN/FLUSH, 13 CBO.INVAL; result bit k of both exception vectors is only set when class bit k is set, and with the output stage on (default) results appear one clock after the inputs. Mode codes are 0 M, 1 HS, 2 HU, 3 VS, 4 VU.
- R2: sfence.vma and hfence.gvma are illegal in HU, and in HS when the trap-virtual-memory bit is set; sfence.vma raises a virtual-instruction exception in VU, or in VS when the guest trap-virtual-memory bit is set; hfence.gvma raises it in VS or VU.
- R3: The partial sfence forms and hfence.vvma are illegal only in HU; the partial sfence forms raise a virtual-instruction exception in VU, hfence.vvma in VS or VU.
- R4: Guest load/store instructions raise a virtual-instruction exception in VS or VU and are illegal in HU when the hypervisor-user-access bit is clear.
- R5: WFI is illegal in HU or in any non-M mode while the timeout-wait bit is set; with that bit clear it raises a virtual-instruction exception in VU, or in VS when the guest timeout-wait bit is set.
- R6: WRS.NTO is illegal in any non-M mode while the timeout-wait bit is set; with it clear it raises a virtual-instruction exception in VS or VU when the guest timeout-wait bit is set.
- R7: Scalar FP and vector FP are illegal while the FP unit is off; integer and FP vector instructions are illegal while the vector unit is off; dynamic-rounding FP is also illegal when the rounding field exceeds 4 (5, 6, 7).
- R8: CBO.ZERO is illegal in non-M modes when the machine zero-enable is clear, or in HU when the supervisor zero-enable is clear; when the machine enable is set it raises a virtual-instruction exception in VS if the hypervisor enable is clear, or in VU if the hypervisor or supervisor enable is clear. CBO.CLEAN/FLUSH follows the same rule with the clean/flush enables.
- R9: The 2-bit invalidate control fields encode 00 off, 01 flush, 11 invalidate, 10 treated as off. CBO.INVAL is illegal in non-M modes when the machine field is off, or in HU when the supervisor field is off; with the machine field not off it raises a virtual-instruction exception in VS if the hypervisor field is off, or in VU if the hypervisor or supervisor field is off.
- R10: The flush output is set only for a CBO.INVAL that raises no exception and when a relevant field holds flush: machine in HS; machine or supervisor in HU; machine or hypervisor in VS; any of the three in VU; never in M.
- R11: An illegal-instruction result masks the virtual-instruction result of the same class, so the two vectors never share a set bit.
- R12: In M mode, and for the reserved mode codes 5 to 7, nothing raises an exception except the FP-off, vector-off and rounding-field checks of R7.
- R13: While reset is asserted all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Current privilege mode code |
| cls_i | input | 14 | One-hot instruction class flags |
| trap_vm_i | input | 1 | Machine status: trap virtual-memory operations |
| timeout_wait_i | input | 1 | Machine status: trap wait instructions |
| vtrap_vm_i | input | 1 | Hypervisor status: trap guest virtual-memory operations |
| vtimeout_wait_i | input | 1 | Hypervisor status: trap guest wait instructions |
| hyp_user_i | input | 1 | Hypervisor status: allow guest load/store from HU |
| fp_off_i | input | 1 | FP unit state is off |
| vec_off_i | input | 1 | Vector unit state is off |
| frm_i | input | 3 | Dynamic rounding mode field |
| m_zero_en_i | input | 1 | Machine env-config zero enable |
| h_zero_en_i | input | 1 | Hypervisor env-config zero enable |
| s_zero_en_i | input | 1 | Supervisor env-config zero enable |
| m_clean_en_i | input | 1 | Machine env-config clean/flush enable |
| h_clean_en_i | input | 1 | Hypervisor env-config clean/flush enable |
| s_clean_en_i | input | 1 | Supervisor env-config clean/flush enable |
| m_inval_ctl_i | input | 2 | Machine env-config invalidate control |
| h_inval_ctl_i | input | 2 | Hypervisor env-config invalidate control |
| s_inval_ctl_i | input | 2 | Supervisor env-config invalidate control |
| ill_o | output | 14 | Per-class illegal-instruction result |
| virt_o | output | 14 | Per-class virtual-instruction result |
| cbo_flush_o | output | 1 | Perform CBO.INVAL as a flush |

## Verification
Every mode code, including the reserved ones, is paired with every class flag and 256 hashed settings of all control fields, so each rule sees both polarities of every bit it depends on and the bits it must ignore change under it; a vector with no class flag checks that nothing fires without a class. Directed vectors separate the rounding values 4 and 5, the reserved invalidate encoding 10 from flush and invalidate, a flush enabled only at the supervisor level in VU against HS, and a reserved mode with every trap bit set. Reset is checked with active inputs held during reset.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

  localparam int NCLS = 14;

  localparam int C_SFV   = 0;
  localparam int C_SFP   = 1;
  localparam int C_HFG   = 2;
  localparam int C_HFV   = 3;
  localparam int C_HLS   = 4;
  localparam int C_WFI   = 5;
  localparam int C_WRS   = 6;
  localparam int C_FP    = 7;
  localparam int C_FPDYN = 8;
  localparam int C_VEC   = 9;
  localparam int C_VECFP = 10;
  localparam int C_CBZ   = 11;
  localparam int C_CBCF  = 12;
  localparam int C_CBI   = 13;

  localparam logic [2:0] MODE_M  = 3'd0;
  localparam logic [2:0] MODE_HS = 3'd1;
  localparam logic [2:0] MODE_HU = 3'd2;
  localparam logic [2:0] MODE_VS = 3'd3;
  localparam logic [2:0] MODE_VU = 3'd4;

  typedef struct packed {
    logic m;
    logic hs;
    logic hu;
    logic vs;
    logic vu;
  } mode_oh_t;

  function automatic logic inval_is_off(input logic [1:0] f);
    return ~f[0];
  endfunction

  function automatic logic inval_is_flush(input logic [1:0] f);
    return (f == 2'b01);
  endfunction

endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
  import priv_chk_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_oh_t   oh_o
);
  always_comb begin
    oh_o    = '0;
    unique case (mode_i)
      MODE_HS: oh_o.hs = 1'b1;
      MODE_HU: oh_o.hu = 1'b1;
      MODE_VS: oh_o.vs = 1'b1;
      MODE_VU: oh_o.vu = 1'b1;
      default: oh_o.m  = 1'b1;  // M and reserved codes
    endcase
  end
endmodule

// File: rtl/priv_fence_wait_rules.sv
module priv_fence_wait_rules
  import priv_chk_pkg::*;
(
  input  mode_oh_t   oh_i,
  input  logic       trap_vm_i,
  input  logic       timeout_wait_i,
  input  logic       vtrap_vm_i,
  input  logic       vtimeout_wait_i,
  input  logic       hyp_user_i,
  output logic [6:0] ill_o,
  output logic [6:0] virt_o
);
  logic guest;
  logic not_m;
  logic vm_trap;

  always_comb begin
    guest   = oh_i.vs | oh_i.vu;
    not_m   = ~oh_i.m;
    vm_trap = oh_i.hu | (oh_i.hs & trap_vm_i);

    ill_o[C_SFV]  = vm_trap;
    virt_o[C_SFV] = oh_i.vu | (oh_i.vs & vtrap_vm_i);

    ill_o[C_SFP]  = oh_i.hu;
    virt_o[C_SFP] = oh_i.vu;

    ill_o[C_HFG]  = vm_trap;
    virt_o[C_HFG] = guest;

    ill_o[C_HFV]  = oh_i.hu;
    virt_o[C_HFV] = guest;

    ill_o[C_HLS]  = oh_i.hu & ~hyp_user_i;
    virt_o[C_HLS] = guest;

    ill_o[C_WFI]  = oh_i.hu | (not_m & timeout_wait_i);
    virt_o[C_WFI] = ~timeout_wait_i & (oh_i.vu | (oh_i.vs & vtimeout_wait_i));

    ill_o[C_WRS]  = not_m & timeout_wait_i;
    virt_o[C_WRS] = guest & ~timeout_wait_i & vtimeout_wait_i;
  end
endmodule

// File: rtl/priv_unit_rules.sv
module priv_unit_rules #(
  parameter int FRM_W   = 3,
  parameter int FRM_MAX = 4
) (
  input  logic             fp_off_i,
  input  logic             vec_off_i,
  input  logic [FRM_W-1:0] frm_i,
  output logic [3:0]       ill_o     // FP, FP-dyn, VEC, VEC-FP
);
  localparam logic [FRM_W-1:0] FRM_LIMIT = FRM_W'(FRM_MAX);

  logic frm_bad;

  always_comb begin
    frm_bad  = (frm_i > FRM_LIMIT);
    ill_o[0] = fp_off_i;
    ill_o[1] = fp_off_i | frm_bad;
    ill_o[2] = vec_off_i;
    ill_o[3] = vec_off_i | fp_off_i;
  end
endmodule

// File: rtl/priv_cbo_rules.sv
module priv_cbo_rules
  import priv_chk_pkg::*;
(
  input  mode_oh_t   oh_i,
  input  logic       m_zero_en_i,
  input  logic       h_zero_en_i,
  input  logic       s_zero_en_i,
  input  logic       m_clean_en_i,
  input  logic       h_clean_en_i,
  input  logic       s_clean_en_i,
  input  logic [1:0] m_inval_ctl_i,
  input  logic [1:0] h_inval_ctl_i,
  input  logic [1:0] s_inval_ctl_i,
  output logic [2:0] ill_o,      // zero, clean/flush, inval
  output logic [2:0] virt_o,
  output logic       flush_o
);
  logic [2:0] m_en, h_en, s_en;
  logic       m_fl, h_fl, s_fl;

  always_comb begin
    m_en = {~inval_is_off(m_inval_ctl_i), m_clean_en_i, m_zero_en_i};
    h_en = {~inval_is_off(h_inval_ctl_i), h_clean_en_i, h_zero_en_i};
    s_en = {~inval_is_off(s_inval_ctl_i), s_clean_en_i, s_zero_en_i};
    m_fl = inval_is_flush(m_inval_ctl_i);
    h_fl = inval_is_flush(h_inval_ctl_i);
    s_fl = inval_is_flush(s_inval_ctl_i);
  end

  for (genvar g = 0; g < 3; g++) begin : g_op
    always_comb begin
      ill_o[g]  = (~oh_i.m & ~m_en[g]) | (oh_i.hu & ~s_en[g]);
      virt_o[g] = m_en[g] & ((oh_i.vs & ~h_en[g]) |
                             (oh_i.vu & (~h_en[g] | ~s_en[g])));
    end
  end

  always_comb begin
    flush_o = (oh_i.hs & m_fl) |
              (oh_i.hu & (m_fl | s_fl)) |
              (oh_i.vs & (m_fl | h_fl)) |
              (oh_i.vu & (m_fl | h_fl | s_fl));
  end
endmodule

// File: rtl/priv_result_stage.sv
module priv_result_stage
  import priv_chk_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLS-1:0] cls_i,
  input  logic [NCLS-1:0] raw_ill_i,
  input  logic [NCLS-1:0] raw_virt_i,
  input  logic            raw_flush_i,
  output logic [NCLS-1:0] ill_o,
  output logic [NCLS-1:0] virt_o,
  output logic            flush_o
);
  logic [NCLS-1:0] ill_d, virt_d;
  logic            flush_d;

  always_comb begin
    ill_d   = cls_i & raw_ill_i;
    virt_d  = cls_i & raw_virt_i & ~raw_ill_i;
    flush_d = cls_i[C_CBI] & raw_flush_i & ~raw_ill_i[C_CBI] & ~raw_virt_i[C_CBI];
  end

  if (OUT_REG) begin : g_reg
    logic [NCLS-1:0] ill_q, virt_q;
    logic            flush_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ill_q   <= '0;
        virt_q  <= '0;
        flush_q <= 1'b0;
      end else begin
        ill_q   <= ill_d;
        virt_q  <= virt_d;
        flush_q <= flush_d;
      end
    end
    assign ill_o   = ill_q;
    assign virt_o  = virt_q;
    assign flush_o = flush_q;
  end else begin : g_comb
    assign ill_o   = rst_ni ? ill_d   : '0;
    assign virt_o  = rst_ni ? virt_d  : '0;
    assign flush_o = rst_ni & flush_d;
  end
endmodule

// File: rtl/priv_legality_chk.sv
module priv_legality_chk
  import priv_chk_pkg::*;
#(
  parameter bit OUT_REG = 1'b1,
  parameter int FRM_W   = 3,
  parameter int FRM_MAX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [NCLS-1:0]  cls_i,
  input  logic             trap_vm_i,
  input  logic             timeout_wait_i,
  input  logic             vtrap_vm_i,
  input  logic             vtimeout_wait_i,
  input  logic             hyp_user_i,
  input  logic             fp_off_i,
  input  logic             vec_off_i,
  input  logic [FRM_W-1:0] frm_i,
  input  logic             m_zero_en_i,
  input  logic             h_zero_en_i,
  input  logic             s_zero_en_i,
  input  logic             m_clean_en_i,
  input  logic             h_clean_en_i,
  input  logic             s_clean_en_i,
  input  logic [1:0]       m_inval_ctl_i,
  input  logic [1:0]       h_inval_ctl_i,
  input  logic [1:0]       s_inval_ctl_i,
  output logic [NCLS-1:0]  ill_o,
  output logic [NCLS-1:0]  virt_o,
  output logic             cbo_flush_o
);
  mode_oh_t        oh;
  logic [6:0]      fw_ill, fw_virt;
  logic [3:0]      un_ill;
  logic [2:0]      cb_ill, cb_virt;
  logic            cb_flush;
  logic [NCLS-1:0] raw_ill, raw_virt;

  priv_mode_decode u_mode (.mode_i(mode_i), .oh_o(oh));

  priv_fence_wait_rules u_fence (
    .oh_i(oh), .trap_vm_i(trap_vm_i), .timeout_wait_i(timeout_wait_i),
    .vtrap_vm_i(vtrap_vm_i), .vtimeout_wait_i(vtimeout_wait_i),
    .hyp_user_i(hyp_user_i), .ill_o(fw_ill), .virt_o(fw_virt)
  );

  priv_unit_rules #(.FRM_W(FRM_W), .FRM_MAX(FRM_MAX)) u_unit (
    .fp_off_i(fp_off_i), .vec_off_i(vec_off_i), .frm_i(frm_i), .ill_o(un_ill)
  );

  priv_cbo_rules u_cbo (
    .oh_i(oh),
    .m_zero_en_i(m_zero_en_i), .h_zero_en_i(h_zero_en_i), .s_zero_en_i(s_zero_en_i),
    .m_clean_en_i(m_clean_en_i), .h_clean_en_i(h_clean_en_i), .s_clean_en_i(s_clean_en_i),
    .m_inval_ctl_i(m_inval_ctl_i), .h_inval_ctl_i(h_inval_ctl_i),
    .s_inval_ctl_i(s_inval_ctl_i),
    .ill_o(cb_ill), .virt_o(cb_virt), .flush_o(cb_flush)
  );

  always_comb begin
    raw_ill  = {cb_ill,  un_ill, fw_ill};
    raw_virt = {cb_virt, 4'b0000, fw_virt};
  end

  priv_result_stage #(.OUT_REG(OUT_REG)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .cls_i(cls_i),
    .raw_ill_i(raw_ill), .raw_virt_i(raw_virt), .raw_flush_i(cb_flush),
    .ill_o(ill_o), .virt_o(virt_o), .flush_o(cbo_flush_o)
  );
endmodule

// File: rtl/priv_legality_chk_sva.sv
module priv_legality_chk_sva
  import priv_chk_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      mode_i,
  input logic [NCLS-1:0] cls_i,
  input logic            fp_off_i,
  input logic [NCLS-1:0] ill_o,
  input logic [NCLS-1:0] virt_o,
  input logic            cbo_flush_o
);
  localparam logic [NCLS-1:0] UNIT_MASK = 14'h0780;

  logic [2:0]      d_mode;
  logic [NCLS-1:0] d_cls;
  logic            d_fp_off;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_mode   <= '0;
        d_cls    <= '0;
        d_fp_off <= 1'b0;
      end else begin
        d_mode   <= mode_i;
        d_cls    <= cls_i;
        d_fp_off <= fp_off_i;
      end
    end
  end else begin : g_nodly
    assign d_mode   = mode_i;
    assign d_cls    = cls_i;
    assign d_fp_off = fp_off_i;
  end

  p_one_kind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ill_o & virt_o) == '0);

  p_class_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ill_o | virt_o) & ~d_cls) == '0);

  p_m_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_mode == 3'd0 || d_mode > 3'd4) |->
      (virt_o == '0 && (ill_o & ~UNIT_MASK) == '0 && !cbo_flush_o));

  p_flush_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbo_flush_o |-> (d_cls[C_CBI] && !ill_o[C_CBI] && !virt_o[C_CBI]));

  p_fp_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_cls[C_FP] && d_fp_off) |-> ill_o[C_FP]);

  p_hu_part_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_mode == 3'd2 && d_cls[C_SFP]) |-> (ill_o[C_SFP] && !virt_o[C_SFP]));
endmodule

bind priv_legality_chk priv_legality_chk_sva #(.OUT_REG(OUT_REG)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cls_i(cls_i),
  .fp_off_i(fp_off_i), .ill_o(ill_o), .virt_o(virt_o), .cbo_flush_o(cbo_flush_o)
);

// File: tb/priv_legality_chk_test.sv
`timescale 1ns/1ps
module priv_legality_chk_test;
  localparam int NC = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] mode;
  logic [NC-1:0] cls;
  logic tvm, tw, vtvm, vtw, huen, fpoff, vecoff;
  logic [2:0] frm;
  logic mz, hz, sz, mc, hc, sc;
  logic [1:0] mi, hi, si;
  logic [NC-1:0] ill, virt;
  logic flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  priv_legality_chk uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .cls_i(cls),
    .trap_vm_i(tvm), .timeout_wait_i(tw), .vtrap_vm_i(vtvm), .vtimeout_wait_i(vtw),
    .hyp_user_i(huen), .fp_off_i(fpoff), .vec_off_i(vecoff), .frm_i(frm),
    .m_zero_en_i(mz), .h_zero_en_i(hz), .s_zero_en_i(sz),
    .m_clean_en_i(mc), .h_clean_en_i(hc), .s_clean_en_i(sc),
    .m_inval_ctl_i(mi), .h_inval_ctl_i(hi), .s_inval_ctl_i(si),
    .ill_o(ill), .virt_o(virt), .cbo_flush_o(flush)
  );

  function automatic string req_of(input int k);
    case (k)
      0, 2:    return "R2";
      1, 3:    return "R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7, 8, 9, 10: return "R7";
      11, 12:  return "R8";
      default: return "R9";
    endcase
  endfunction

  // Expected results, written from the requirements
  task automatic model(output logic [NC-1:0] ei, output logic [NC-1:0] ev, output logic ef);
    logic m, hs, hu, vs, vu, nm, gst;
    logic [NC-1:0] ri, rv;
    logic moff, hoff, soff, mfl, hfl, sfl, fl;
    m  = (mode == 3'd0) || (mode > 3'd4);
    hs = (mode == 3'd1); hu = (mode == 3'd2);
    vs = (mode == 3'd3); vu = (mode == 3'd4);
    nm = !m; gst = vs | vu;
    ri = '0; rv = '0;
    ri[0] = hu | (hs & tvm);        rv[0] = vu | (vs & vtvm);
    ri[1] = hu;                     rv[1] = vu;
    ri[2] = hu | (hs & tvm);        rv[2] = gst;
    ri[3] = hu;                     rv[3] = gst;
    ri[4] = hu & !huen;             rv[4] = gst;
    ri[5] = hu | (nm & tw);         rv[5] = (vu & !tw) | (vs & !tw & vtw);
    ri[6] = nm & tw;                rv[6] = gst & !tw & vtw;
    ri[7] = fpoff;
    ri[8] = fpoff | (frm > 3'd4);
    ri[9] = vecoff;
    ri[10] = fpoff | vecoff;
    ri[11] = (nm & !mz) | (hu & !sz);
    rv[11] = mz & ((vs & !hz) | (vu & (!hz | !sz)));
    ri[12] = (nm & !mc) | (hu & !sc);
    rv[12] = mc & ((vs & !hc) | (vu & (!hc | !sc)));
    moff = !(mi == 2'b01 || mi == 2'b11);
    hoff = !(hi == 2'b01 || hi == 2'b11);
    soff = !(si == 2'b01 || si == 2'b11);
    ri[13] = (nm & moff) | (hu & soff);
    rv[13] = !moff & ((vs & hoff) | (vu & (hoff | soff)));
    mfl = (mi == 2'b01); hfl = (hi == 2'b01); sfl = (si == 2'b01);
    fl = (hs & mfl) | (hu & (mfl | sfl)) | (vs & (mfl | hfl)) | (vu & (mfl | hfl | sfl));
    ei = cls & ri;
    ev = cls & rv & ~ri;
    ef = cls[13] & fl & !ri[13] & !rv[13];
  endtask

  task automatic set_ctl(input logic [31:0] h);
    tvm = h[0]; tw = h[1]; vtvm = h[2]; vtw = h[3]; huen = h[4];
    fpoff = h[5]; vecoff = h[6]; frm = h[9:7];
    mz = h[10]; hz = h[11]; sz = h[12]; mc = h[13]; hc = h[14]; sc = h[15];
    mi = h[17:16]; hi = h[19:18]; si = h[21:20];
  endtask

  // inputs already driven after a negedge; results appear after the next posedge
  task automatic step_check(input string tag);
    logic [NC-1:0] ei, ev;
    logic ef;
    model(ei, ev, ef);
    @(posedge clk);
    #1;
    checks++;
    if (ill !== ei || virt !== ev || flush !== ef) begin
      fails++;
      $display("FAIL %s mode=%0d cls=%h: ill=%h virt=%h flush=%b expected ill=%h virt=%h flush=%b",
               tag, mode, cls, ill, virt, flush, ei, ev, ef);
    end
    @(negedge clk);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    mode = 3'd2;
    cls  = '1;
    set_ctl(32'hFFFF_FFFF);
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R13 reset state
    if (ill !== '0 || virt !== '0 || flush !== 1'b0) begin
      fails++;
      $display("FAIL R13 reset: ill=%h virt=%h flush=%b expected all zero", ill, virt, flush);
    end
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: no class flag, nothing fires
    cls = '0; mode = 3'd2; set_ctl(32'h0000_0060);
    step_check("R1 no class");

    // Sweep: every mode code, every class, hashed control settings
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < NC; k++) begin
        for (int p = 0; p < 256; p++) begin
          mode = 3'(m);
          cls  = NC'(1) << k;
          set_ctl((32'(p) * 32'h9E37_79B1) ^ (32'(k) * 32'h85EB_CA6B) ^ (32'(m) * 32'hC2B2_AE35));
          step_check((m > 4 || m == 0) ? "R12" : req_of(k));
        end
      end
    end

    // R7: rounding boundary 4 legal, 5 illegal
    set_ctl(32'h0); mode = 3'd1; cls = NC'(1) << 8;
    frm = 3'd4; step_check("R7 frm=4");
    frm = 3'd5; step_check("R7 frm=5");

    // R9: reserved encoding 10 behaves as off; 11 and 01 do not
    set_ctl(32'h0); mode = 3'd1; cls = NC'(1) << 13;
    mi = 2'b10; step_check("R9 cbie=10 off");
    mi = 2'b11; step_check("R9 cbie=11 inval");
    mode = 3'd3; hi = 2'b10; step_check("R9 VS guest cbie=10");

    // R10: flush requested only by supervisor field
    set_ctl(32'h0); cls = NC'(1) << 13;
    mi = 2'b11; hi = 2'b11; si = 2'b01;
    mode = 3'd4; step_check("R10 VU flush via senv");
    mode = 3'd1; step_check("R10 HS ignores senv");
    mode = 3'd0; mi = 2'b01; step_check("R10 M never flush");

    // R11/R5: WFI in VS with trap bits set -> illegal wins
    set_ctl(32'h0); tw = 1'b1; vtw = 1'b1; mode = 3'd3; cls = NC'(1) << 5;
    step_check("R11 WFI VS illegal over virtual");

    // R12: reserved mode with all trap bits, FP unit on
    set_ctl(32'hFFFF_FF9F); mode = 3'd6; cls = NC'(1) << 5;
    step_check("R12 reserved mode");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule